// File: doc/BRIEF.md
# Bit-Serial Constant-Coefficient Dot Product

This block computes the weighted sum of N signed sample words against a set of coefficients that are fixed when the design is elaborated. It uses no multiplier.

A start pulse captures all N samples in parallel. On each following cycle the block gathers one bit from every sample, all at the same bit position. Those N bits form an address into a constant table. Each table entry holds the sum of the coefficients whose address bit is set. The selected entry is folded into a shifting accumulator. The bit positions are walked from least significant to most significant. After one step per sample bit, the block raises a single-cycle done pulse, and the result port holds the exact sum.

A parent uses the block as one output lane of a fixed linear transform. It drives the sample bus, pulses start, and takes the result when done rises. The result stays put until the next start. A parameter selects whether samples are read as two's-complement or unsigned.

Top module: `dap_dot`

## Requirements
- R1: A synchronous reset, including one asserted part-way through a computation, leaves done low and the result at zero until the next start.
- R2: Sample i (bits [i*X_W +: X_W] of the sample bus) drives address bit i of the table. Coefficient i (bits [i*COEF_W +: COEF_W] of the coefficient parameter) contributes to every entry whose address bit i is 1. A run with only sample i equal to 1 therefore yields coefficient i.
- R3: In signed mode the result equals the sum over i of coefficient i times sample i, with samples read as X_W-bit two's-complement. This holds for mixed signs and for the most negative sample value.
- R4: done rises exactly X_W clock edges after the edge that samples start, and stays high for exactly one cycle.
- R5: After done, the result holds its value on every cycle until the next start or reset.
- R6: A start while a computation is running discards that computation. No done appears for it, and a new computation begins with the samples present at the new start.
- R7: Changes on the sample bus after the start edge have no effect on the result of the running computation.
- R8: With coefficients 5 and 3 on inputs 0 and 1, zeros elsewhere, and samples 1 and 2, the result is 11.
- R9: In unsigned mode (SIGNED_X = 0) every bit position, including the top one, adds its table entry. An all-ones sample then counts as 2^X_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture samples and begin (or restart) a computation |
| x_bus | input | N_IN*X_W | Packed samples, sample i at [i*X_W +: X_W] |
| res | output | OUT_W | Result slice of the accumulator starting at OUT_LSB |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The hardest situations to reach from the ports are the abandoned computations. One is a second start arriving while the step counter is mid-way. The other is a reset landing in the middle of a run. In both, the stale run must produce no done and leave no partial sum behind. The bench launches a run, waits a few cycles, and then either issues a fresh start with different samples or pulses reset. It then watches every cycle: done must stay low until exactly X_W edges after the new start, or must not appear at all after the reset. Sample-bus changes right after the start edge, and samples of the most negative value, cover the capture and the sign-bit step.

// File: rtl/dap_pkg.sv
package dap_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } dap_phase_e;

   // smallest r with 2**r >= v
   function automatic int ceil_log2(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dap_lut.sv
// Constant subset-sum table realised as a multiplexer over fixed entries.
module dap_lut #(
   parameter int N_IN   = 4,
   parameter int COEF_W = 8,
   parameter int TBL_W  = 10,
   parameter logic [N_IN*COEF_W-1:0] COEFS = '0
) (
   input  logic [N_IN-1:0]         addr,
   output logic signed [TBL_W-1:0] entry
);
   localparam int DEPTH = 1 << N_IN;

   function automatic logic signed [TBL_W-1:0] subset_sum(input int a);
      logic signed [TBL_W-1:0] s;
      logic [COEF_W-1:0]       c;
      s = '0;
      for (int i = 0; i < N_IN; i++) begin
         c = COEFS[i*COEF_W +: COEF_W];
         if (a[i]) s = s + {{(TBL_W-COEF_W){c[COEF_W-1]}}, c};
      end
      return s;
   endfunction

   logic signed [TBL_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      localparam logic signed [TBL_W-1:0] ENT = subset_sum(g);
      assign rom[g] = ENT;
   end

   assign entry = rom[addr];

endmodule

// File: rtl/dap_slicer.sv
// Holds the captured samples and presents one bit of each per step, LSB first.
module dap_slicer #(
   parameter int N_IN = 4,
   parameter int X_W  = 12
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic                  shift,
   input  logic [N_IN*X_W-1:0]   x_bus,
   output logic [N_IN-1:0]       addr
);
   for (genvar i = 0; i < N_IN; i++) begin : g_lane
      logic [X_W-1:0] sr;

      always_ff @(posedge clk) begin
         if (rst)        sr <= '0;
         else if (load)  sr <= x_bus[i*X_W +: X_W];
         else if (shift) sr <= {1'b0, sr[X_W-1:1]};
      end

      assign addr[i] = sr[0];
   end

endmodule

// File: rtl/dap_acc.sv
// Shift-right accumulator: each entry enters at weight 2^(X_W-1) and is
// halved on every later step, so step k ends up weighted by 2^k.
module dap_acc #(
   parameter int TBL_W    = 10,
   parameter int X_W      = 12,
   parameter int ACC_W    = 22,
   parameter bit SIGNED_X = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    step_en,
   input  logic                    last,
   input  logic signed [TBL_W-1:0] entry,
   output logic signed [ACC_W-1:0] acc_q
);
   logic signed [ACC_W-1:0] ent_ext;
   logic signed [ACC_W-1:0] ent_top;
   logic signed [ACC_W-1:0] shifted;
   logic signed [ACC_W-1:0] acc_d;
   logic                    sub;

   assign ent_ext = {{(ACC_W-TBL_W){entry[TBL_W-1]}}, entry};
   assign ent_top = ent_ext <<< (X_W-1);
   assign shifted = acc_q >>> 1;
   assign sub     = last && SIGNED_X;

   always_comb begin
      if (sub) acc_d = shifted - ent_top;   // sign-bit position carries -2^(X_W-1)
      else     acc_d = shifted + ent_top;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) acc_q <= '0;
      else if (step_en) acc_q <= acc_d;
   end

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!clr && !step_en) |=> $stable(acc_q));                       // R5
   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
      clr |=> (acc_q == '0));                                        // R6

endmodule

// File: rtl/dap_ctrl.sv
// Step sequencer: start always wins and restarts the count.
module dap_ctrl
   import dap_pkg::*;
#(
   parameter int X_W = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic step_en,
   output logic last,
   output logic done
);
   localparam int            CNT_W    = (ceil_log2(X_W) < 1) ? 1 : ceil_log2(X_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(X_W - 1);

   dap_phase_e       phase;
   logic [CNT_W-1:0] cnt;

   assign load    = start;
   assign step_en = (phase == PH_RUN) && !start;
   assign last    = step_en && (cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            phase <= PH_RUN;
            cnt   <= '0;
         end else if (step_en) begin
            if (last) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                               // R4
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      last |=> done);                                                // R4
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN) |-> (cnt <= CNT_LAST));                      // R4
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
      start |=> (phase == PH_RUN && cnt == '0 && !done));            // R6

endmodule

// File: rtl/dap_dot.sv
module dap_dot
   import dap_pkg::*;
#(
   parameter int N_IN     = 4,
   parameter int X_W      = 12,
   parameter int COEF_W   = 8,
   parameter logic [N_IN*COEF_W-1:0] COEFS = 32'h0BF9_0305,
   parameter bit SIGNED_X = 1'b1,
   parameter int OUT_LSB  = 0,
   parameter int OUT_W    = COEF_W + ceil_log2(N_IN) + X_W + (SIGNED_X ? 0 : 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [N_IN*X_W-1:0]   x_bus,
   output logic [OUT_W-1:0]      res,
   output logic                  done
);
   localparam int TBL_W = COEF_W + ceil_log2(N_IN);
   localparam int ACC_W = TBL_W + X_W + (SIGNED_X ? 0 : 1);

   if (N_IN < 2 || N_IN > 8) begin : g_bad_n
      $error("dap_dot: N_IN must lie in 2..8");
   end
   if (X_W < 2) begin : g_bad_x
      $error("dap_dot: X_W must be at least 2");
   end
   if (COEF_W < 2) begin : g_bad_c
      $error("dap_dot: COEF_W must be at least 2");
   end
   if (OUT_LSB < 0 || OUT_W < 1 || OUT_LSB + OUT_W > ACC_W) begin : g_bad_out
      $error("dap_dot: result slice exceeds the accumulator");
   end

   logic                    load;
   logic                    step_en;
   logic                    last;
   logic [N_IN-1:0]         addr;
   logic signed [TBL_W-1:0] entry;
   logic signed [ACC_W-1:0] acc_q;

   dap_ctrl #(.X_W(X_W)) u_ctrl (
      .clk(clk), .rst(rst), .start(start),
      .load(load), .step_en(step_en), .last(last), .done(done)
   );

   dap_slicer #(.N_IN(N_IN), .X_W(X_W)) u_slicer (
      .clk(clk), .rst(rst), .load(load), .shift(step_en),
      .x_bus(x_bus), .addr(addr)
   );

   dap_lut #(.N_IN(N_IN), .COEF_W(COEF_W), .TBL_W(TBL_W), .COEFS(COEFS)) u_lut (
      .addr(addr), .entry(entry)
   );

   dap_acc #(.TBL_W(TBL_W), .X_W(X_W), .ACC_W(ACC_W), .SIGNED_X(SIGNED_X)) u_acc (
      .clk(clk), .rst(rst), .clr(load), .step_en(step_en), .last(last),
      .entry(entry), .acc_q(acc_q)
   );

   assign res = acc_q[OUT_LSB +: OUT_W];

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!done && res == '0));                          // R1

endmodule

// File: tb/dap_dot_test.sv
`timescale 1ns/1ps
module dap_dot_test;
   localparam int N_IN = 4;
   localparam int X_W  = 12;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                start = 1'b0;
   logic [N_IN*X_W-1:0] x_bus = '0;
   logic [21:0]         res;
   logic [22:0]         res_u;
   logic                done;
   logic                done_u;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dap_dot uut (
      .clk(clk), .rst(rst), .start(start), .x_bus(x_bus), .res(res), .done(done)
   );

   dap_dot #(.SIGNED_X(1'b0)) uut_u (
      .clk(clk), .rst(rst), .start(start), .x_bus(x_bus), .res(res_u), .done(done_u)
   );

   // coefficients: input0=5, input1=3, input2=-7, input3=11
   function automatic int exp_s(input int a, input int b, input int c, input int d);
      return 5*a + 3*b - 7*c + 11*d;
   endfunction

   function automatic int exp_u(input int a, input int b, input int c, input int d);
      return 5*(a & 32'hFFF) + 3*(b & 32'hFFF) - 7*(c & 32'hFFF) + 11*(d & 32'hFFF);
   endfunction

   function automatic logic [47:0] pk(input int a, input int b, input int c, input int d);
      return {12'(d), 12'(c), 12'(b), 12'(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic launch(input logic [47:0] v);
      @(negedge clk);
      x_bus = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // called right after launch: watch X_W edges, then check result and hold
   task automatic finish_run(input string req, input int es, input int eu);
      int early;
      int r_s;
      int r_u;
      early = 0;
      for (int k = 1; k <= X_W; k++) begin
         @(negedge clk);
         if (k < X_W && (done || done_u)) early++;
      end
      chk(early == 0, "R4", "done before last step", early, 0);
      chk(done && done_u, "R4", "done at step X_W", int'(done), 1);
      r_s = int'($signed(res));
      r_u = int'($signed(res_u));
      chk(r_s == es, req, "signed result", r_s, es);
      chk(r_u == eu, "R9", "unsigned result", r_u, eu);
      @(negedge clk);
      chk(!done && !done_u, "R4", "done one cycle only", int'(done), 0);
      repeat (3) @(negedge clk);
      chk(int'($signed(res)) == es, "R5", "result held", int'($signed(res)), es);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(!done && res == '0 && res_u == '0, "R1", "reset state", int'(res), 0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_example();   // R8
      launch(pk(1, 2, 0, 0));
      finish_run("R8", 11, exp_u(1, 2, 0, 0));
   endtask

   task automatic t_single_inputs();   // R2
      launch(pk(1, 0, 0, 0)); finish_run("R2", 5, 5);
      launch(pk(0, 1, 0, 0)); finish_run("R2", 3, 3);
      launch(pk(0, 0, 1, 0)); finish_run("R2", -7, -7);
      launch(pk(0, 0, 0, 1)); finish_run("R2", 11, 11);
   endtask

   task automatic t_signed_mix();   // R3
      launch(pk(-1, -2048, 2047, 100));
      finish_run("R3", exp_s(-1, -2048, 2047, 100), exp_u(-1, -2048, 2047, 100));
      launch(pk(-2048, -2048, -2048, -2048));
      finish_run("R3", -24576, 24576);
      launch(pk(-1, 0, 0, 0));   // R9: all-ones counts as 4095 unsigned
      finish_run("R3", -5, 20475);
   endtask

   task automatic t_restart();   // R6
      int early;
      early = 0;
      launch(pk(300, 1, 1, 1));
      repeat (3) begin
         @(negedge clk);
         if (done) early++;
      end
      launch(pk(-5, 7, -9, 13));
      chk(early == 0 && !done, "R6", "no done from abandoned run", early, 0);
      finish_run("R6", exp_s(-5, 7, -9, 13), exp_u(-5, 7, -9, 13));
   endtask

   task automatic t_ignore_bus();   // R7
      launch(pk(17, -33, 45, -61));
      x_bus = pk(-2048, 2047, -1, 1234);
      finish_run("R7", exp_s(17, -33, 45, -61), exp_u(17, -33, 45, -61));
   endtask

   task automatic t_reset_mid();   // R1
      int seen;
      seen = 0;
      launch(pk(99, 99, 99, 99));
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (done || done_u) seen++;
      end
      chk(seen == 0, "R1", "no done after mid-run reset", seen, 0);
      chk(res == '0 && res_u == '0, "R1", "result cleared by reset", int'(res), 0);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_example();
      t_single_inputs();
      t_signed_mix();
      t_restart();
      t_ignore_bus();
      t_reset_mid();
      report();
   end

   initial begin
      #(20 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule